// File: doc/BRIEF.md
# Offset-Correcting Fine Gain Stage

This block post-processes a stream of signed 14-bit converter samples. Each sample arrives with a valid strobe. The block can first remove a slowly varying DC component. It does this with a leaky integrating loop: an accumulator sums every corrected sample, and a right shift of that accumulator forms the offset estimate, which is subtracted from the incoming data. The length of the shift sets the loop time constant. A 4-bit code selects it, and each step of the code doubles the number of samples the loop averages over.

After the subtraction, a fine gain from 0 dB to 6 dB in half-decibel steps scales the sample. The gain is a fixed-point multiplier in Q2.14 with round-to-nearest, and the result is clamped to the signed 14-bit range. The enable, the time-constant code and the gain code are all taken together with the sample they accompany. Each corrected sample leaves the block two clock cycles after it entered.

Top module: `ofc_offset_gain_top`

## Requirements
- R1: A sample accepted on a rising edge with `in_valid` high appears on `out_valid`/`out_data` after exactly two rising edges. `out_valid` is low for every cycle that carries no sample.
- R2: While `rst` is high on a rising edge, the accumulator, the offset estimate and both pipeline stages clear. After reset, `out_valid` and `out_data` read 0.
- R3: For gain code n from 0 to 12, the multiplier is K(n) = round(16384 × 10^(n/40)). The output is (x × K(n) + 8192) >> 14 using arithmetic shift, so code 0 passes the sample unchanged.
- R4: Gain codes 13, 14 and 15 give the same result as code 12 (6 dB).
- R5: The gained result saturates to the range −8192 to +8191.
- R6: With `corr_en` low, the sample passes to the gain stage unmodified, and the accumulator and estimate keep their values.
- R7: With `corr_en` high, the corrected value is sat14(x − E), where E is the current estimate.
- R8: With `corr_en` high and a time-constant code c of 0 to 11, the corrected value is added to the accumulator on that sample. E then becomes sat14(acc >>> (BASE_SHIFT + c)). With the default BASE_SHIFT of 18, code 0 averages over 2^18 samples and code 11 over 2^29.
- R9: With `corr_en` high and a time-constant code of 12 to 15, the accumulator does not update and E holds. Subtraction with the held E still applies.
- R10: A constant input with correction enabled is driven towards zero at the output.
- R11: `corr_en`, `tc_code` and `gain_code` act on the sample presented in the same cycle. Changing them between consecutive samples affects only the later samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 14 | Signed input sample |
| corr_en | input | 1 | Offset correction enable |
| tc_code | input | 4 | Loop time-constant code (12 to 15 hold the loop) |
| gain_code | input | 4 | Fine gain in 0.5 dB steps (13 to 15 act as 12) |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 14 | Signed corrected and gained sample |

## Verification
The in-line properties check several things on every cycle:
- the two-cycle alignment between the input and output strobes;
- that the accumulator and estimate stay frozen while correction is off;
- that the estimate holds under a reserved time-constant code;
- that disabled correction is a pure pass-through;
- that gain code 0 is unity.

Other behaviour can only be shown by the bench's scenarios, run against an independent model:
- the actual gain values and their rounding;
- the saturation points;
- the exact evolution of the offset estimate under each time constant;
- the convergence of a DC input towards zero.

// File: rtl/ofc_pkg.sv
package ofc_pkg;

    localparam int CODE_W        = 4;
    localparam int COEF_W        = 16;
    localparam int COEF_FRAC     = 14;
    localparam int GAIN_TOP_CODE = 12;

    typedef logic [CODE_W-1:0] code_t;

    // How the loop treats the current sample
    typedef struct packed {
        logic apply;   // subtract the estimate
        logic learn;   // update accumulator and estimate
    } loop_mode_t;

    // Outcome of a range clamp
    typedef enum logic [1:0] {
        CLAMP_NONE = 2'd0,
        CLAMP_HIGH = 2'd1,
        CLAMP_LOW  = 2'd2
    } clamp_e;

    function automatic loop_mode_t loop_mode(input logic en, input code_t tc,
                                             input code_t tc_max);
        loop_mode_t m;
        m.apply = en;
        m.learn = en && (tc <= tc_max);
        return m;
    endfunction

    // Q2.14 multiplier: round(16384 * 10^(n/40)); codes above 12 use the 6 dB entry
    function automatic logic [COEF_W-1:0] gain_coef(input code_t g);
        logic [COEF_W-1:0] k;
        case (g)
            4'd0:    k = 16'd16384;
            4'd1:    k = 16'd17355;
            4'd2:    k = 16'd18383;
            4'd3:    k = 16'd19472;
            4'd4:    k = 16'd20626;
            4'd5:    k = 16'd21848;
            4'd6:    k = 16'd23143;
            4'd7:    k = 16'd24514;
            4'd8:    k = 16'd25967;
            4'd9:    k = 16'd27506;
            4'd10:   k = 16'd29135;
            4'd11:   k = 16'd30862;
            default: k = 16'd32690;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ofc_offset_loop.sv
module ofc_offset_loop
    import ofc_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int BASE_SHIFT  = 18,
    parameter int MAX_TC_CODE = 11,
    parameter int ACC_W       = DATA_W + BASE_SHIFT + MAX_TC_CODE
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     corr_en,
    input  code_t                    tc_code,
    input  code_t                    gain_code,
    output logic                     s1_valid,
    output logic signed [DATA_W-1:0] s1_data,
    output code_t                    s1_gain
);

    localparam int SH_W = $clog2(BASE_SHIFT + (1 << CODE_W));

    localparam logic signed [DATA_W-1:0] D_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] D_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0]  A_MAX = ACC_W'(D_MAX);
    localparam logic signed [ACC_W-1:0]  A_MIN = ACC_W'(D_MIN);

    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_sum;
    logic signed [ACC_W-1:0]  acc_shr;
    logic signed [DATA_W-1:0] est_q;
    logic signed [DATA_W-1:0] est_next;
    logic signed [DATA_W-1:0] corr_c;
    logic signed [DATA_W:0]   diff;
    logic [SH_W-1:0]          shamt;
    loop_mode_t               mode;
    clamp_e                   diff_clamp;

    always_comb begin
        mode = loop_mode(corr_en, tc_code, code_t'(MAX_TC_CODE));

        diff = (DATA_W+1)'(in_data) - (DATA_W+1)'(est_q);
        if (diff[DATA_W] != diff[DATA_W-1])
            diff_clamp = diff[DATA_W] ? CLAMP_LOW : CLAMP_HIGH;
        else
            diff_clamp = CLAMP_NONE;

        if (!mode.apply)
            corr_c = in_data;
        else begin
            case (diff_clamp)
                CLAMP_HIGH: corr_c = D_MAX;
                CLAMP_LOW:  corr_c = D_MIN;
                default:    corr_c = diff[DATA_W-1:0];
            endcase
        end

        acc_sum = acc_q + ACC_W'(corr_c);
        shamt   = SH_W'(BASE_SHIFT) + SH_W'(tc_code);
        acc_shr = acc_sum >>> shamt;

        if (acc_shr > A_MAX)
            est_next = D_MAX;
        else if (acc_shr < A_MIN)
            est_next = D_MIN;
        else
            est_next = acc_shr[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            est_q    <= '0;
            s1_valid <= 1'b0;
            s1_data  <= '0;
            s1_gain  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_data <= corr_c;
                s1_gain <= gain_code;
            end
            if (in_valid && mode.learn) begin
                acc_q <= acc_sum;
                est_q <= est_next;
            end
        end
    end

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !corr_en |=> ($stable(acc_q) && $stable(est_q))); // R6

    AST_BYPASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !corr_en) |=> (s1_data == $past(in_data))); // R6

    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (corr_en && (tc_code > code_t'(MAX_TC_CODE))) |=> $stable(est_q)); // R9

endmodule

// File: rtl/ofc_gain_stage.sv
module ofc_gain_stage
    import ofc_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     s1_valid,
    input  logic signed [DATA_W-1:0] s1_data,
    input  code_t                    s1_gain,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int PROD_W = DATA_W + COEF_W + 1;

    localparam logic signed [DATA_W-1:0] D_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] D_MIN = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [PROD_W-1:0] P_MAX = PROD_W'(D_MAX);
    localparam logic signed [PROD_W-1:0] P_MIN = PROD_W'(D_MIN);
    localparam logic signed [PROD_W-1:0] HALF  = PROD_W'(1) <<< (COEF_FRAC - 1);

    logic [COEF_W-1:0]        coef;
    logic signed [PROD_W-1:0] op_a;
    logic signed [PROD_W-1:0] op_b;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;
    logic signed [DATA_W-1:0] res;
    clamp_e                   clamp;

    always_comb begin
        coef = gain_coef(s1_gain);
        op_a = PROD_W'(s1_data);
        op_b = PROD_W'($signed({1'b0, coef}));
        prod = op_a * op_b;
        rnd  = (prod + HALF) >>> COEF_FRAC;

        if (rnd > P_MAX)
            clamp = CLAMP_HIGH;
        else if (rnd < P_MIN)
            clamp = CLAMP_LOW;
        else
            clamp = CLAMP_NONE;

        case (clamp)
            CLAMP_HIGH: res = D_MAX;
            CLAMP_LOW:  res = D_MIN;
            default:    res = rnd[DATA_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_data <= res;
        end
    end

    AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && (s1_gain == '0)) |=> (out_data == $past(s1_data))); // R3

endmodule

// File: rtl/ofc_offset_gain_top.sv
module ofc_offset_gain_top
    import ofc_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int BASE_SHIFT  = 18,
    parameter int MAX_TC_CODE = 11
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    input  logic                     corr_en,
    input  logic [3:0]               tc_code,
    input  logic [3:0]               gain_code,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int ACC_W = DATA_W + BASE_SHIFT + MAX_TC_CODE;

    logic                     s1_valid;
    logic signed [DATA_W-1:0] s1_data;
    code_t                    s1_gain;

    ofc_offset_loop #(
        .DATA_W      (DATA_W),
        .BASE_SHIFT  (BASE_SHIFT),
        .MAX_TC_CODE (MAX_TC_CODE),
        .ACC_W       (ACC_W)
    ) u_loop (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .corr_en   (corr_en),
        .tc_code   (tc_code),
        .gain_code (gain_code),
        .s1_valid  (s1_valid),
        .s1_data   (s1_data),
        .s1_gain   (s1_gain)
    );

    ofc_gain_stage #(
        .DATA_W (DATA_W)
    ) u_gain (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_data   (s1_data),
        .s1_gain   (s1_gain),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2)); // R1

    AST_IN_REACHES_OUT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid); // R1

endmodule

// File: tb/tb_ofc_offset_gain_top.sv
module tb_ofc_offset_gain_top;

    localparam int BS     = 2;
    localparam int TC_MAX = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [13:0] in_data = '0;
    logic              corr_en = 1'b0;
    logic [3:0]        tc_code = '0;
    logic [3:0]        gain_code = '0;
    logic              out_valid;
    logic signed [13:0] out_data;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R2";
    bit    done = 1'b0;

    longint m_acc = 0;
    int     m_est = 0;
    bit     pv0 = 0, pv1 = 0;
    int     pd0 = 0, pd1 = 0;
    int     last_out = 0;

    always #4 clk = ~clk;

    ofc_offset_gain_top #(
        .DATA_W      (14),
        .BASE_SHIFT  (BS),
        .MAX_TC_CODE (TC_MAX)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .corr_en   (corr_en),
        .tc_code   (tc_code),
        .gain_code (gain_code),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic int sat14(input longint v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return int'(v);
    endfunction

    function automatic longint coef_of(input int g);
        int  n;
        real r;
        n = (g > 12) ? 12 : g;
        r = 16384.0 * (10.0 ** (real'(n) / 40.0));
        return longint'($rtoi(r + 0.5));
    endfunction

    function automatic int model(input int d, input bit en, input int tc, input int g);
        int     c;
        longint p;
        c = en ? sat14(longint'(d) - longint'(m_est)) : d;
        if (en && tc <= TC_MAX) begin
            m_acc = m_acc + longint'(c);
            m_est = sat14(m_acc >>> (BS + tc));
        end
        p = longint'(c) * coef_of(g);
        return sat14((p + 8192) >>> 14);
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic step(input bit v, input int d, input bit en, input int tc, input int g);
        @(negedge clk);
        checks++;
        if (out_valid !== pv1 || (pv1 && int'(out_data) != pd1)) begin
            errors++;
            $display("FAIL %s: got valid=%0b data=%0d, expected valid=%0b data=%0d",
                     cur_req, out_valid, out_data, pv1, pd1);
        end
        if (out_valid === 1'b1) last_out = int'(out_data);
        pv1 = pv0;
        pd1 = pd0;
        in_valid  = v;
        in_data   = d[13:0];
        corr_en   = en;
        tc_code   = tc[3:0];
        gain_code = g[3:0];
        pv0 = v;
        if (v) pd0 = model(d, en, tc, g);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R2: cleared outputs while and after reset
        checks++;
        if (out_valid !== 1'b0 || out_data !== 14'sd0) begin
            errors++;
            $display("FAIL R2: got valid=%0b data=%0d, expected 0/0", out_valid, out_data);
        end
        rst = 1'b0;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);

        // R3: every gain code, both signs
        cur_req = "R3";
        for (int g = 0; g <= 12; g++) begin
            step(1, 4000, 0, 0, g);
            step(1, -3001, 0, 0, g);
            step(1, 1, 0, 0, g);
        end
        // R4: codes above 12 act as 6 dB
        cur_req = "R4";
        for (int g = 13; g <= 15; g++) step(1, 3000, 0, 0, g);
        // R5: saturation at both ends
        cur_req = "R5";
        step(1, 8191, 0, 0, 12);
        step(1, -8192, 0, 0, 12);
        step(1, 6000, 0, 0, 9);
        step(1, -5000, 0, 0, 15);
        // R1: gaps between samples
        cur_req = "R1";
        step(1, 100, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(1, -100, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(1, 77, 0, 0, 3);
        // R6: disabled passes data, loop frozen
        cur_req = "R6";
        for (int i = 0; i < 8; i++) step(1, 500 + i, 0, i, 0);
        // R10: DC converges to zero
        cur_req = "R10";
        for (int i = 0; i < 300; i++) step(1, 1000, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        checks++;
        if (last_out > 4 || last_out < -4) begin
            errors++;
            $display("FAIL R10: residual %0d, expected within +-4", last_out);
        end
        // R7 and R8: subtraction and learning over several time constants
        cur_req = "R8";
        for (int tc = 1; tc <= 3; tc++)
            for (int i = 0; i < 40; i++) step(1, (i % 2) ? 2500 : -700, 1, tc, 0);
        cur_req = "R7";
        for (int i = 0; i < 10; i++) step(1, -8000, 1, 0, 0);
        // R9: reserved code holds the estimate, subtraction continues
        cur_req = "R9";
        for (int i = 0; i < 20; i++) step(1, 2000 + i, 1, 12 + (i % 4), 0);
        // R6: loop re-enabled after a frozen stretch
        cur_req = "R6";
        for (int i = 0; i < 10; i++) step(1, 300, 0, 0, 0);
        for (int i = 0; i < 10; i++) step(1, 300, 1, 1, 0);
        // R11: controls change on every sample
        cur_req = "R11";
        for (int i = 0; i < 30; i++) step(1, 1500 - 100 * i, i % 2, i % 5, i % 16);
        // R8: random mix
        cur_req = "R8";
        for (int i = 0; i < 4000; i++) begin
            step(($urandom_range(3) != 0), int'($urandom_range(16383)) - 8192,
                 ($urandom_range(3) != 0), int'($urandom_range(15)), int'($urandom_range(15)));
        end
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule